// File: doc/BRIEF.md
# MDIO Management Frame Master

This block runs clause-22 management transactions on an MDC/MDIO pair. A host sets a PHY address, a register address, a read or write flag and, for writes, 16 data bits. It then pulses `start`. The block divides the system clock down to MDC and shifts the frame out. On reads it checks that the PHY takes over the line correctly during turnaround. It returns the 16 data bits with a valid flag or an error flag, plus an optional error interrupt pulse.

The MDIO pad itself stays outside the block. The block exposes a drive value, an output enable and the sampled input. While no transaction runs, MDC stays low and the output enable is off. Outgoing bits change on the falling edge of MDC, and the PHY's bits are captured on the rising edge.

The block also tracks whether the 32-bit preamble may be left out. A valid read of the status register with its suppression-capable bit set makes later frames start directly with the start field. A read error, a disconnect indication or reset brings the preamble back. A fast-rate input halves the MDC period for a single well-behaved PHY.

Top module: `mdio_master`

## Requirements
- R1: Whenever `busy` is low, `mdc` is 0 and `mdio_oe` is 0.
- R2: With preamble active, a frame spans 65 MDC rising edges. The first 32 drive 1. The next 32 carry start (0 then 1), opcode, PHY address and register address (each 5 bits, MSB first), turnaround and data (MSB first). The last rising edge has MDIO released.
- R3: The opcode is driven as 1,0 for a read and 0,1 for a write.
- R4: On a write, turnaround is driven as 1 then 0, followed by `wr_data` MSB first.
- R5: On a read, MDIO is released from the first turnaround bit through the last data bit. The 16 bits on `mdio_i` at the data rising edges are returned MSB first on `rd_data`, with `rd_ok` high.
- R6: If `mdio_i` is not 0 at the second turnaround rising edge of a read, `rd_err` is 1, `rd_ok` is 0 and `rd_data` is 0.
- R7: `err_irq` pulses together with `done` only for a read error while `irq_en` is 1.
- R8: After a valid read of register 1 returns data bit 6 set, later frames omit the preamble and span 33 MDC rising edges. A later valid read of register 1 with bit 6 clear restores the preamble.
- R9: A read error, a pulse on `phy_disconnect`, or reset restores the preamble for the next frame.
- R10: Each MDC high and low phase lasts HALF_SLOW system clocks, or HALF_FAST clocks when `fast_mdc` was 1 at the start request.
- R11: `busy` rises on the clock after an accepted `start` and stays high until the idle bit ends. `done` is then a single-cycle pulse. A `start` while busy is ignored and produces no frame and no extra `done`.
- R12: `mdio_o` and `mdio_oe` change during a transaction only on the system clock where MDC falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Transaction request, taken when idle |
| rd_req | input | 1 | 1 = read, 0 = write |
| phy_addr | input | 5 | Target PHY address |
| reg_addr | input | 5 | Target register address |
| wr_data | input | 16 | Data for a write |
| fast_mdc | input | 1 | Selects the short MDC period |
| irq_en | input | 1 | Enables the read-error interrupt pulse |
| phy_disconnect | input | 1 | Clears the learned preamble suppression |
| mdio_i | input | 1 | Sampled MDIO line |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO drive value |
| mdio_oe | output | 1 | MDIO drive enable |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 16 | Data from the last valid read |
| rd_ok | output | 1 | Last transaction was a valid read |
| rd_err | output | 1 | Last transaction was a failed read |
| err_irq | output | 1 | Read-error interrupt pulse |

## Verification
Writes and reads use contrasting address and data patterns at both MDC rates. This separates opcode, turnaround and bit-order mistakes and confirms the phase length of each rate. Reads are answered with a good and a bad turnaround bit, with the interrupt enable both on and off, so the valid, error and interrupt paths are each seen alone. Status reads with bit 6 set and clear are followed by frames whose length shows the learned preamble state. That state is then knocked out in turn by an error, a disconnect and a reset. A start pulsed mid-frame must leave the frame unchanged and add no completion.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

    localparam int PRE_BITS   = 32;
    localparam int FRAME_BITS = 32;
    localparam int IDLE_IDX   = PRE_BITS + FRAME_BITS;
    localparam int IDX_W      = $clog2(IDLE_IDX + 1);
    localparam int TA2_POS    = 15;  // frame position of the second turnaround bit
    localparam int TA1_POS    = 14;
    localparam logic [4:0] STATUS_REG  = 5'd1;
    localparam int         NOPRE_BIT   = 6;

    typedef enum logic [1:0] {
        OP_WRITE = 2'b01,
        OP_READ  = 2'b10
    } mdio_op_e;

    typedef struct packed {
        logic [1:0]  st;
        mdio_op_e    op;
        logic [4:0]  phy;
        logic [4:0]  regad;
        logic [1:0]  ta;
        logic [15:0] data;
    } mdio_frame_t;

    function automatic mdio_frame_t build_frame(input logic rd, input logic [4:0] pa,
                                                input logic [4:0] ra, input logic [15:0] wd);
        mdio_frame_t f;
        f.st    = 2'b01;
        f.op    = rd ? OP_READ : OP_WRITE;
        f.phy   = pa;
        f.regad = ra;
        f.ta    = rd ? 2'b00 : 2'b10;
        f.data  = rd ? 16'h0000 : wd;
        return f;
    endfunction

endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
    parameter int HALF_SLOW = 10,
    parameter int HALF_FAST = 5
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic fast,
    output logic mdc,
    output logic rise_stb,
    output logic fall_stb
);
    localparam int CW = $clog2(HALF_SLOW + 1);
    localparam logic [CW-1:0] LIM_SLOW = CW'(HALF_SLOW - 1);
    localparam logic [CW-1:0] LIM_FAST = CW'(HALF_FAST - 1);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] lim;
    logic          wrap;

    assign lim      = fast ? LIM_FAST : LIM_SLOW;
    assign wrap     = en && (cnt_q == lim);
    assign rise_stb = wrap && !mdc;
    assign fall_stb = wrap && mdc;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            cnt_q <= '0;
            mdc   <= 1'b0;
        end else if (wrap) begin
            cnt_q <= '0;
            mdc   <= ~mdc;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R10: the MDC level only moves while the divider is enabled
    assert_mdc_gated_R10: assert property (@(posedge clk) disable iff (rst)
        !$past(en) |-> !mdc);

endmodule

// File: rtl/mdio_pre_track.sv
module mdio_pre_track (
    input  logic clk,
    input  logic rst,
    input  logic disconnect,
    input  logic upd,
    input  logic ta_ok,
    input  logic is_status,
    input  logic cap_bit,
    output logic suppress
);
    always_ff @(posedge clk) begin
        if (rst || disconnect) begin
            suppress <= 1'b0;
        end else if (upd) begin
            if (!ta_ok)         suppress <= 1'b0;
            else if (is_status) suppress <= cap_bit;
        end
    end

    assert_disc_clears_R9: assert property (@(posedge clk) disable iff (rst)
        disconnect |=> !suppress);

    assert_err_clears_R9: assert property (@(posedge clk) disable iff (rst)
        (upd && !ta_ok) |=> !suppress);

endmodule

// File: rtl/mdio_master.sv
module mdio_master
    import mdio_pkg::*;
#(
    parameter int HALF_SLOW = 10,
    parameter int HALF_FAST = 5
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  logic        rd_req,
    input  logic [4:0]  phy_addr,
    input  logic [4:0]  reg_addr,
    input  logic [15:0] wr_data,
    input  logic        fast_mdc,
    input  logic        irq_en,
    input  logic        phy_disconnect,
    input  logic        mdio_i,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    output logic        busy,
    output logic        done,
    output logic [15:0] rd_data,
    output logic        rd_ok,
    output logic        rd_err,
    output logic        err_irq
);
    localparam logic [IDX_W-1:0] IDX_FRAME = IDX_W'(PRE_BITS);
    localparam logic [IDX_W-1:0] IDX_LAST  = IDX_W'(IDLE_IDX);

    logic [IDX_W-1:0] idx_q;
    mdio_frame_t      frm_q;
    logic             is_rd_q, fast_q, ta_ok_q, suppress;
    logic [15:0]      sh_q;
    logic             rise_stb, fall_stb;
    logic             accept, last_bit, in_pre, in_frm, released, learn_upd;
    logic [4:0]       fpos;

    assign accept    = start && !busy;
    assign last_bit  = idx_q == IDX_LAST;
    assign in_pre    = idx_q < IDX_FRAME;
    assign in_frm    = !in_pre && !last_bit;
    assign fpos      = idx_q[4:0];
    assign released  = is_rd_q && (fpos >= 5'(TA1_POS));
    assign learn_upd = busy && fall_stb && last_bit && is_rd_q;

    always_comb begin
        mdio_oe = busy && (in_pre || (in_frm && !released));
        mdio_o  = mdio_oe && (in_pre || frm_q[5'd31 - fpos]);
    end

    mdio_clkgen #(.HALF_SLOW(HALF_SLOW), .HALF_FAST(HALF_FAST)) u_clk (
        .clk(clk), .rst(rst), .en(busy), .fast(fast_q),
        .mdc(mdc), .rise_stb(rise_stb), .fall_stb(fall_stb)
    );

    mdio_pre_track u_pre (
        .clk(clk), .rst(rst), .disconnect(phy_disconnect), .upd(learn_upd),
        .ta_ok(ta_ok_q), .is_status(frm_q.regad == STATUS_REG),
        .cap_bit(sh_q[NOPRE_BIT]), .suppress(suppress)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            busy    <= 1'b0;
            done    <= 1'b0;
            err_irq <= 1'b0;
            rd_ok   <= 1'b0;
            rd_err  <= 1'b0;
            rd_data <= '0;
            idx_q   <= '0;
            frm_q   <= '0;
            is_rd_q <= 1'b0;
            fast_q  <= 1'b0;
            ta_ok_q <= 1'b0;
            sh_q    <= '0;
        end else begin
            done    <= 1'b0;
            err_irq <= 1'b0;
            if (accept) begin
                busy    <= 1'b1;
                idx_q   <= suppress ? IDX_FRAME : '0;
                frm_q   <= build_frame(rd_req, phy_addr, reg_addr, wr_data);
                is_rd_q <= rd_req;
                fast_q  <= fast_mdc;
                ta_ok_q <= 1'b0;
            end else if (busy) begin
                if (rise_stb && is_rd_q && in_frm) begin
                    if (fpos == 5'(TA2_POS))     ta_ok_q <= !mdio_i;
                    else if (fpos > 5'(TA2_POS)) sh_q    <= {sh_q[14:0], mdio_i};
                end
                if (fall_stb) begin
                    if (last_bit) begin
                        busy    <= 1'b0;
                        done    <= 1'b1;
                        rd_ok   <= is_rd_q && ta_ok_q;
                        rd_err  <= is_rd_q && !ta_ok_q;
                        err_irq <= is_rd_q && !ta_ok_q && irq_en;
                        if (is_rd_q) rd_data <= ta_ok_q ? sh_q : 16'h0000;
                    end else begin
                        idx_q <= idx_q + 1'b1;
                    end
                end
            end
        end
    end

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!mdc && !mdio_oe));

    assert_mdio_on_fall_R12: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy) && (!$stable(mdio_o) || !$stable(mdio_oe))) |-> $fell(mdc));

    assert_done_single_R11: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_busy_on_start_R11: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> busy);

    assert_irq_with_err_R7: assert property (@(posedge clk) disable iff (rst)
        err_irq |-> (done && rd_err));

    assert_flags_excl_R6: assert property (@(posedge clk) disable iff (rst)
        !(rd_ok && rd_err));

endmodule

// File: tb/tb_mdio_master.sv
module tb_mdio_master;
    localparam int CLK_P = 10;
    localparam int HS = 10;
    localparam int HF = 5;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0, rd_req = 1'b0, fast_mdc = 1'b0, irq_en = 1'b0, phy_disconnect = 1'b0;
    logic [4:0] phy_addr = '0, reg_addr = '0;
    logic [15:0] wr_data = '0;
    logic mdio_i;
    logic mdc, mdio_o, mdio_oe, busy, done, rd_ok, rd_err, err_irq;
    logic [15:0] rd_data;

    always #(CLK_P/2) clk = ~clk;

    mdio_master #(.HALF_SLOW(HS), .HALF_FAST(HF)) dut (
        .clk(clk), .rst(rst), .start(start), .rd_req(rd_req), .phy_addr(phy_addr),
        .reg_addr(reg_addr), .wr_data(wr_data), .fast_mdc(fast_mdc), .irq_en(irq_en),
        .phy_disconnect(phy_disconnect), .mdio_i(mdio_i), .mdc(mdc), .mdio_o(mdio_o),
        .mdio_oe(mdio_oe), .busy(busy), .done(done), .rd_data(rd_data), .rd_ok(rd_ok),
        .rd_err(rd_err), .err_irq(err_irq)
    );

    typedef struct {
        logic [64:0] oe;
        logic [64:0] val;
        int          n;
        int          half;
        logic        ok, err, irq;
        logic [15:0] data;
    } exp_t;

    exp_t        sbq[$];
    logic [64:0] resp = '1;
    logic [64:0] cap_oe = '0, cap_val = '0;
    int          rc = 0, hi = 0, done_cnt = 0;
    bit          fell_seen = 0;
    logic        mdc_q = 0;
    int          nchk = 0, nfail = 0;
    bit          exp_sup = 0;
    logic [15:0] last_data = '0;
    bit          finished = 0;

    task automatic chk(input bit ok, input string tag, input logic [64:0] act, input logic [64:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s: act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    // monitor / PHY responder / scoreboard consumer
    always @(negedge clk) begin
        if (rst) begin
            rc = 0; hi = 0; fell_seen = 0; mdc_q = 0; mdio_i = 1'b1;
        end else begin
            if (mdc && !mdc_q) begin
                if (rc < 65) begin cap_oe[rc] = mdio_oe; cap_val[rc] = mdio_o; end
                rc++;
            end
            if (!mdc && mdc_q) begin
                fell_seen = 1;
                mdio_i = (rc < 65) ? resp[rc] : 1'b1;
            end
            if (mdc && !fell_seen) hi++;
            mdc_q = mdc;
            if (done) begin
                done_cnt++;
                if (sbq.size() == 0) begin
                    chk(0, "R11 unexpected done", 1, 0);
                end else begin
                    exp_t e;
                    logic [64:0] m;
                    e = sbq.pop_front();
                    m = (65'd1 << e.n) - 65'd1;
                    chk(rc == e.n, "R2 R8 rising edge count", 65'(rc), 65'(e.n));
                    chk((cap_oe & m) == e.oe, "R2 R4 R5 drive enable pattern", cap_oe & m, e.oe);
                    chk((cap_val & cap_oe & m) == e.val, "R2 R3 R4 driven bits", cap_val & cap_oe & m, e.val);
                    chk(hi == e.half, "R10 MDC high phase", 65'(hi), 65'(e.half));
                    chk(rd_ok == e.ok, "R5 rd_ok", 65'(rd_ok), 65'(e.ok));
                    chk(rd_err == e.err, "R6 rd_err", 65'(rd_err), 65'(e.err));
                    chk(rd_data == e.data, "R5 R6 rd_data", 65'(rd_data), 65'(e.data));
                    chk(err_irq == e.irq, "R7 err_irq", 65'(err_irq), 65'(e.irq));
                end
                rc = 0; hi = 0; fell_seen = 0; mdio_i = 1'b1;
            end
        end
    end

    task automatic push_frame(input bit rd, input logic [4:0] pa, input logic [4:0] ra,
                              input logic [15:0] d, input bit fast, input bit ta_good, input bit ien);
        exp_t e;
        int p;
        logic [31:0] w;
        p = exp_sup ? 0 : 32;
        e.n = p + 33;
        e.half = fast ? HF : HS;
        w = {2'b01, (rd ? 2'b10 : 2'b01), pa, ra, (rd ? 2'b00 : 2'b10), (rd ? 16'h0 : d)};
        e.oe = '0; e.val = '0; resp = '1;
        for (int i = 0; i < p; i++) begin e.oe[i] = 1'b1; e.val[i] = 1'b1; end
        for (int f = 0; f < 32; f++) begin
            e.oe[p+f]  = !(rd && f >= 14);
            e.val[p+f] = e.oe[p+f] && w[31-f];
        end
        if (rd) begin
            resp[p+15] = !ta_good;
            for (int k = 0; k < 16; k++) resp[p+16+k] = d[15-k];
        end
        e.ok = rd && ta_good;
        e.err = rd && !ta_good;
        e.irq = e.err && ien;
        e.data = rd ? (ta_good ? d : 16'h0) : last_data;
        last_data = e.data;
        if (rd) begin
            if (!ta_good) exp_sup = 0;
            else if (ra == 5'd1) exp_sup = d[6];
        end
        sbq.push_back(e);
        @(negedge clk);
        rd_req = rd; phy_addr = pa; reg_addr = ra; wr_data = d;
        fast_mdc = fast; irq_en = ien; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_drain();
        wait (sbq.size() == 0);
        @(negedge clk);
        chk(!busy && !mdc && !mdio_oe, "R1 idle after frame", {62'd0, busy, mdc, mdio_oe}, 0);
    endtask

    task automatic do_frame(input bit rd, input logic [4:0] pa, input logic [4:0] ra,
                            input logic [15:0] d, input bit fast, input bit ta_good, input bit ien);
        push_frame(rd, pa, ra, d, fast, ta_good, ien);
        wait_drain();
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        exp_sup = 0; last_data = '0;
        @(negedge clk);
        chk(!busy && !mdc && !mdio_oe && !done, "R1 reset state", {61'd0, busy, mdc, mdio_oe, done}, 0);
        chk(rd_data == 16'h0 && !rd_ok && !rd_err, "R1 reset results", 65'(rd_data), 0);
    endtask

    initial begin
        #(CLK_P * 150000);
        if (!finished) begin
            nfail++;
            $display("FAIL R11 watchdog: act=running exp=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
            $finish;
        end
    end

    initial begin
        int dc;
        do_reset();
        // R2 R3 R4 R10: write, slow rate
        do_frame(0, 5'h05, 5'h00, 16'hA5C3, 0, 1, 0);
        // R5 R10: read, fast rate, good turnaround
        do_frame(1, 5'h11, 5'h02, 16'h1234, 1, 1, 0);
        // R8: learn suppression from status register
        do_frame(1, 5'h01, 5'h01, 16'h0040, 0, 1, 0);
        do_frame(0, 5'h1A, 5'h15, 16'h5A3C, 0, 1, 0);
        // R6 R7 R9: read error with interrupt enabled clears suppression
        do_frame(1, 5'h02, 5'h03, 16'hFFFF, 0, 0, 1);
        do_frame(0, 5'h03, 5'h04, 16'h0001, 1, 1, 1);
        // R6 R7: read error with interrupt disabled
        do_frame(1, 5'h04, 5'h1F, 16'h8000, 1, 0, 0);
        // R9: disconnect clears learned state
        do_frame(1, 5'h01, 5'h01, 16'hFFFF, 0, 1, 0);
        @(negedge clk); phy_disconnect = 1'b1; @(negedge clk); phy_disconnect = 1'b0;
        exp_sup = 0;
        do_frame(0, 5'h07, 5'h08, 16'h00FF, 0, 1, 0);
        // R9: reset clears learned state
        do_frame(1, 5'h01, 5'h01, 16'h0040, 1, 1, 0);
        do_reset();
        do_frame(1, 5'h09, 5'h0A, 16'hBEEF, 0, 1, 0);
        // R8: status read with bit 6 clear restores preamble
        do_frame(1, 5'h01, 5'h01, 16'h7FFF, 0, 1, 0);
        do_frame(1, 5'h01, 5'h01, 16'hFFBF, 0, 1, 0);
        do_frame(0, 5'h0C, 5'h0D, 16'h1357, 1, 1, 0);
        // R11: start while busy is ignored
        dc = done_cnt;
        push_frame(0, 5'h0E, 5'h06, 16'hC001, 0, 1, 0);
        repeat (200) @(negedge clk);
        chk(busy, "R11 busy mid-frame", 65'(busy), 1);
        rd_req = 1; phy_addr = 5'h1F; reg_addr = 5'h1F; wr_data = 16'h0; start = 1'b1;
        @(negedge clk); start = 1'b0;
        wait_drain();
        repeat (1500) @(negedge clk);
        chk(done_cnt == dc + 1, "R11 single done per accepted start", 65'(done_cnt), 65'(dc + 1));
        chk(!busy, "R11 busy cleared", 65'(busy), 0);
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

endmodule